// File: doc/BRIEF.md
# Outstanding Line Miss Table

This block tracks cache-line misses that are waiting on the next memory level. Each slot holds a valid flag, the line address (the byte address with the offset bits already removed) and a flag that records whether the read request for that line has been sent. A new miss is compared against every valid slot in the same cycle. If one slot already holds the line, the miss is reported as merged into that slot and no new memory traffic is created. If no slot holds the line, the miss takes the lowest free slot.

Allocating a slot and sending its request are separate steps. Unsent slots are offered to memory one per cycle through a valid/ready handshake, lowest index first. The slot index serves as the transaction tag. A response names its slot by that tag and frees the slot, and responses may arrive in any order. A full flag lets the pipeline stall when every slot is occupied.

Top module: `mshr_file`

## Requirements
- R1: After reset no slot is occupied: `full_o` is 0 and `req_valid_o` is 0.
- R2: A miss whose line equals the line of an occupied slot, where that slot is not freed in the same cycle, raises `miss_merge_o` in the same cycle and reports that slot on `miss_idx_o`. No slot is allocated.
- R3: A miss that matches no slot, arriving while a slot is free, raises `miss_alloc_o` in the same cycle and reports the lowest-numbered free slot on `miss_idx_o`. That slot holds the line from the next cycle.
- R4: `full_o` is 1 exactly when every slot is occupied. While it is 1, a miss that matches no slot raises neither `miss_merge_o` nor `miss_alloc_o`.
- R5: `req_valid_o` is 1 whenever an occupied slot is unsent. `req_tag_o` is then the lowest such slot and `req_line_o` is its line. A cycle with `req_valid_o` and `req_ready_i` both high marks that slot as sent, and the slot is not offered again.
- R6: A newly allocated slot can be offered on the request port from the cycle after its allocation, and not earlier.
- R7: A cycle with `rsp_valid_i` high frees slot `rsp_tag_i` at the clock edge. From the next cycle that slot counts as free and its line no longer matches.
- R8: A miss to the line of the slot that is being freed in the same cycle does not merge. It allocates a different free slot when one exists.
- R9: Responses may return in any order relative to the order of the requests. Each response frees only the slot it names.
- R10: The table never holds the same line in two occupied slots, so at most one slot matches any miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | New miss presented this cycle |
| miss_line_i | input | LINE_W | Line address of the miss |
| miss_merge_o | output | 1 | Miss joins an occupied slot |
| miss_alloc_o | output | 1 | Miss takes a free slot |
| miss_idx_o | output | $clog2(ENTRIES) | Slot that was merged into or allocated |
| full_o | output | 1 | Every slot occupied |
| req_valid_o | output | 1 | A read request is offered to memory |
| req_ready_i | input | 1 | Memory accepts the offered request |
| req_line_o | output | LINE_W | Line address of the offered request |
| req_tag_o | output | $clog2(ENTRIES) | Slot index used as the transaction tag |
| rsp_valid_i | input | 1 | Fill response returns this cycle |
| rsp_tag_i | input | $clog2(ENTRIES) | Slot named by the response |

## Verification
The merge and allocation results are combinational on the miss inputs, so they are due in the same cycle as the miss. The bench samples them 1 ns after driving the inputs on the falling edge. Slot occupancy, the full flag and the request port change only at the next rising edge after an allocation, handshake or response. The bench's behavioural model of the table applies each cycle's update at the same edge, and the next comparison follows on the falling edge after it. This keeps the one-cycle delay of R3, R6 and R7 exact. Responses are drawn at random among the slots the model knows to be sent, which covers out-of-order return and a fill that collides with a miss to the same line.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  parameter int unsigned ENTRIES_DEF = 8;
  parameter int unsigned LINE_W_DEF  = 26;
endpackage

// File: rtl/mshr_pick.sv
module mshr_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mshr_cam.sv
module mshr_cam #(
  parameter int unsigned N  = 8,
  parameter int unsigned LW = 26
) (
  input  logic [N-1:0]  live_i,
  input  logic [LW-1:0] line_i [N],
  input  logic [LW-1:0] key_i,
  output logic [N-1:0]  hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_o[g] = live_i[g] && (line_i[g] == key_i);
  end
endmodule

// File: rtl/mshr_file.sv
module mshr_file
  import mshr_pkg::*;
#(
  parameter int unsigned ENTRIES = ENTRIES_DEF,
  parameter int unsigned LINE_W  = LINE_W_DEF,
  localparam int unsigned IW     = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_valid_i,
  input  logic [LINE_W-1:0] miss_line_i,
  output logic              miss_merge_o,
  output logic              miss_alloc_o,
  output logic [IW-1:0]     miss_idx_o,
  output logic              full_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [LINE_W-1:0] req_line_o,
  output logic [IW-1:0]     req_tag_o,
  input  logic              rsp_valid_i,
  input  logic [IW-1:0]     rsp_tag_i
);
  logic [ENTRIES-1:0] vld_q, iss_q, rsp_clr, hit_vec, free_vec, pend_vec;
  logic [LINE_W-1:0]  line_q [ENTRIES];
  logic               hit_any, free_any, fire;
  logic [IW-1:0]      hit_idx, free_idx;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_clr
    assign rsp_clr[g] = rsp_valid_i && (rsp_tag_i == IW'(g));
  end

  // slot being freed this cycle must not absorb a merge
  mshr_cam #(.N(ENTRIES), .LW(LINE_W)) u_cam (
    .live_i (vld_q & ~rsp_clr),
    .line_i (line_q),
    .key_i  (miss_line_i),
    .hit_o  (hit_vec)
  );

  mshr_pick #(.N(ENTRIES), .IW(IW)) u_pick_hit (
    .req_i (hit_vec), .found_o (hit_any), .idx_o (hit_idx)
  );

  assign free_vec = ~vld_q;
  mshr_pick #(.N(ENTRIES), .IW(IW)) u_pick_free (
    .req_i (free_vec), .found_o (free_any), .idx_o (free_idx)
  );

  assign pend_vec = vld_q & ~iss_q;
  mshr_pick #(.N(ENTRIES), .IW(IW)) u_pick_iss (
    .req_i (pend_vec), .found_o (req_valid_o), .idx_o (req_tag_o)
  );

  assign miss_merge_o = miss_valid_i && hit_any;
  assign miss_alloc_o = miss_valid_i && !hit_any && free_any;
  assign miss_idx_o   = hit_any ? hit_idx : free_idx;
  assign full_o       = &vld_q;
  assign req_line_o   = line_q[req_tag_o];
  assign fire         = req_valid_o && req_ready_i;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g]  <= 1'b0;
        iss_q[g]  <= 1'b0;
        line_q[g] <= '0;
      end else if (rsp_clr[g]) begin
        vld_q[g] <= 1'b0;
        iss_q[g] <= 1'b0;
      end else if (miss_alloc_o && free_idx == IW'(g)) begin
        vld_q[g]  <= 1'b1;
        iss_q[g]  <= 1'b0;
        line_q[g] <= miss_line_i;
      end else if (fire && req_tag_o == IW'(g)) begin
        iss_q[g] <= 1'b1;
      end
    end
  end

  a_r10_single_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
  a_r2_merge_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(miss_merge_o && miss_alloc_o));
  a_r4_full_no_alloc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !miss_alloc_o);
  a_r8_no_merge_freed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_i && miss_merge_o) |-> (miss_idx_o != rsp_tag_i));
  a_r3_alloc_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_alloc_o |=> vld_q[$past(miss_idx_o)]);
  a_r5_sent_marked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> iss_q[$past(req_tag_o)]);
  a_r7_freed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i |=> !vld_q[$past(rsp_tag_i)]);
  a_r9_rsp_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i |-> (vld_q[rsp_tag_i] && iss_q[rsp_tag_i]));
endmodule

// File: tb/mshr_file_tb.sv
module mshr_file_tb;
  localparam int N  = 8;
  localparam int LW = 26;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          miss_valid = 1'b0;
  logic [LW-1:0] miss_line = '0;
  logic          miss_merge, miss_alloc, full, req_valid;
  logic [IW-1:0] miss_idx, req_tag;
  logic          req_ready = 1'b0;
  logic [LW-1:0] req_line;
  logic          rsp_valid = 1'b0;
  logic [IW-1:0] rsp_tag = '0;

  int checks = 0;
  int fails  = 0;

  bit          m_vld [N];
  bit          m_iss [N];
  logic [LW-1:0] m_line [N];

  always #5 clk = ~clk;

  mshr_file #(.ENTRIES(N), .LINE_W(LW)) u_dut (
    .clk_i (clk), .rst_ni (rst_n),
    .miss_valid_i (miss_valid), .miss_line_i (miss_line),
    .miss_merge_o (miss_merge), .miss_alloc_o (miss_alloc), .miss_idx_o (miss_idx),
    .full_o (full),
    .req_valid_o (req_valid), .req_ready_i (req_ready),
    .req_line_o (req_line), .req_tag_o (req_tag),
    .rsp_valid_i (rsp_valid), .rsp_tag_i (rsp_tag)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", rq, act, exp, $time);
    end
  endtask

  // one clock: drive, compare against the model, advance the model
  task automatic step(input bit mv, input logic [LW-1:0] ln, input bit rdy,
                      input bit rv, input int tg);
    bit e_merge, e_alloc, e_full, e_req;
    int e_idx, e_tag;
    @(negedge clk);
    miss_valid = mv; miss_line = ln; req_ready = rdy;
    rsp_valid = rv; rsp_tag = IW'(tg);
    #1;
    e_merge = 0; e_alloc = 0; e_idx = -1; e_req = 0; e_tag = -1; e_full = 1;
    for (int i = 0; i < N; i++) begin
      if (mv && m_vld[i] && !(rv && tg == i) && m_line[i] == ln) begin
        e_merge = 1; e_idx = i;
      end
      if (!m_vld[i]) e_full = 0;
    end
    if (mv && !e_merge) begin
      for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) begin e_alloc = 1; e_idx = i; end
    end
    for (int i = N - 1; i >= 0; i--) if (m_vld[i] && !m_iss[i]) begin e_req = 1; e_tag = i; end
    chk(miss_merge == e_merge, "R2/R8 merge", int'(miss_merge), int'(e_merge));
    chk(miss_alloc == e_alloc, "R3/R4 alloc", int'(miss_alloc), int'(e_alloc));
    if (e_merge || e_alloc) chk(int'(miss_idx) == e_idx, "R2/R3 idx", int'(miss_idx), e_idx);
    chk(full == e_full, "R4 full", int'(full), int'(e_full));
    chk(req_valid == e_req, "R5/R6 req_valid", int'(req_valid), int'(e_req));
    if (e_req) begin
      chk(int'(req_tag) == e_tag, "R5 req_tag", int'(req_tag), e_tag);
      chk(req_line == m_line[e_tag], "R5 req_line", int'(req_line), int'(m_line[e_tag]));
    end
    @(posedge clk);
    if (rv) begin m_vld[tg] = 0; m_iss[tg] = 0; end   // R7 / R9
    if (e_alloc) begin m_vld[e_idx] = 1; m_iss[e_idx] = 0; m_line[e_idx] = ln; end
    if (e_req && rdy) m_iss[e_tag] = 1;
  endtask

  function automatic int pick_sent(input int start);
    for (int k = 0; k < N; k++) begin
      int j = (start + k) % N;
      if (m_vld[j] && m_iss[j]) return j;
    end
    return -1;
  endfunction

  initial begin
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_iss[i] = 0; m_line[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(full == 1'b0, "R1 full after reset", int'(full), 0);
    chk(req_valid == 1'b0, "R1 req_valid after reset", int'(req_valid), 0);

    // R3 allocate, R2 merge, R6 issue visible the cycle after allocation
    step(1, 26'h100, 0, 0, 0);
    step(1, 26'h100, 0, 0, 0);
    step(1, 26'h200, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    // R4 fill to full and try a miss that matches nothing
    for (int i = 2; i < N; i++) step(1, LW'(26'h300 + i), 0, 0, 0);
    step(1, 26'h3FF, 0, 0, 0);
    step(1, 26'h305, 0, 0, 0);
    // send everything
    for (int i = 0; i < N; i++) step(0, 0, 1, 0, 0);
    // R9 out-of-order returns
    step(0, 0, 0, 1, 5);
    step(0, 0, 0, 1, 2);
    // R8 miss to the line being freed allocates elsewhere
    step(1, 26'h100, 0, 1, 0);
    // R7 freed slot's line no longer matches
    step(1, 26'h200, 0, 1, 1);
    step(1, 26'h200, 1, 0, 0);

    // randomised traffic over a small line set
    for (int c = 0; c < 3000; c++) begin
      int t = pick_sent(int'($urandom_range(0, N - 1)));
      bit rv = (t >= 0) && ($urandom_range(0, 2) != 0);
      step($urandom_range(0, 3) != 0, LW'($urandom_range(0, 11)),
           $urandom_range(0, 1) == 1, rv, rv ? t : 0);
    end
    step(0, 0, 0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule